// File: doc/BRIEF.md
# CPU status flag register

This block keeps the processor's condition and machine-state flags. Four ALU condition flags (overflow, carry, zero, negative) are written together as one group. The source of that group is either the ALU's flag outputs, for an arithmetic step, or the low bits of the Z bus, so that a status byte saved earlier can be restored. Two machine-state flags, Interrupts Enabled and Supervisor mode, are written one at a time. Each takes a single bit from the Z bus, so the microcode sets or clears a flag by having the ALU drive all ones or all zeros.

All six flags go to the microprogram sequencer continuously, with no gating. When the status register is selected as the Left bus source, the flags are also driven onto the Left bus so they can be saved to memory. Writes happen at the rising edge of `clk_i`, which is the mid-cycle strobe (the inverted CPU clock). The active-low CPU reset clears every flag at that same edge.

Top module: `status_flag_reg`

## Requirements
- R1: With `alu_ld_i`=1 at a rising edge of `clk_i`, the four ALU flags take new values. These values appear on `seq_flags_o[3:0]` after that edge.
- R2: The ALU flag source depends on `alu_src_i`. When it is 1, the flags load from `alu_flags_i`. When it is 0, they load from `z_bus_i[3:0]`. In both sources the bit order is bit0=C, bit1=Z, bit2=N, bit3=V.
- R3: With `alu_ld_i`=0 at an edge, the four ALU flags keep their values, whatever `alu_src_i`, `alu_flags_i` and `z_bus_i` are.
- R4: With `st_ld_i[k]`=1 at an edge, state flag k loads `z_bus_i[4+k]`. Index k=0 is Interrupts Enabled (bit 4) and k=1 is Supervisor (bit 5).
- R5: A state flag whose `st_ld_i` bit is 0 keeps its value, even when the matching Z bus bit changes.
- R6: When several selects are active at the same edge, the ALU group and each selected state flag update independently and correctly.
- R7: With `rst_ni`=0 at an edge, all six flags become 0. Reset wins over any load that is active at the same edge.
- R8: `seq_flags_o` always shows the current flags, ungated. Bits [3:0] are the ALU flags in R2 order, bit 4 is Interrupts Enabled and bit 5 is Supervisor.
- R9: When `left_sel_i`=1, `left_o` shows the flags in the R8 layout, with bits 7:6 at 0. When `left_sel_i`=0, `left_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Mid-cycle write strobe (inverted CPU clock) |
| rst_ni | input | 1 | Active-low CPU reset, synchronous clear |
| alu_ld_i | input | 1 | Load select for the ALU flag group |
| alu_src_i | input | 1 | ALU flag source: 1 = ALU outputs, 0 = Z bus |
| alu_flags_i | input | 4 | Flags computed by the ALU (C, Z, N, V from bit 0) |
| st_ld_i | input | 2 | Per-flag load selects: [0] Interrupts Enabled, [1] Supervisor |
| z_bus_i | input | 8 | Z bus (ALU output bus) |
| left_sel_i | input | 1 | Status register selected as the Left bus source |
| seq_flags_o | output | 6 | Flags to the sequencer, always valid |
| left_o | output | 8 | Left bus contribution, zero when not selected |

## Verification
The bench builds the block with its default parameters: four ALU flags, two state flags and an eight-bit bus. With these values every flag position can be reached, along with the two padding bits that must read zero on the Left bus.

The scenarios cover the following cases:
- Reset is held while all loads are active.
- Both ALU flag sources are used, with Z bus data whose state-flag bits are set.
- Each state flag is set and then cleared on its own.
- All selects fire at once.
- Reset is applied mid-run.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  parameter int unsigned ALU_FLAG_W   = 4;
  parameter int unsigned STATE_FLAG_W = 2;
  parameter int unsigned BUS_W        = 8;
  localparam int unsigned FLAG_W      = ALU_FLAG_W + STATE_FLAG_W;
  localparam int unsigned STATE_BASE  = ALU_FLAG_W;

  // bit positions on the Z/Left buses and on the sequencer output
  typedef enum int unsigned {
    POS_C   = 0,
    POS_Z   = 1,
    POS_N   = 2,
    POS_V   = 3,
    POS_IE  = 4,
    POS_SUP = 5
  } flag_pos_e;
endpackage

// File: rtl/alu_flag_grp.sv
module alu_flag_grp #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         src_i,
  input  logic [W-1:0] alu_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;

  always_comb d = src_i ? alu_i : z_i;

  // synchronous clear, reset wins over load
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d;
  end

  assert_alu_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == ($past(src_i) ? $past(alu_i) : $past(z_i))));

  assert_alu_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/state_flag_cell.sv
module state_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (ld_i) q_o <= d_i;
  end

  assert_state_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (q_o == $past(d_i)));

  assert_state_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
endmodule

// File: rtl/flag_bus_drv.sv
module flag_bus_drv #(
  parameter int unsigned FLAG_W = 6,
  parameter int unsigned BUS_W  = 8
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              sel_i,
  output logic [BUS_W-1:0]  bus_o
);
  localparam int unsigned PAD_W = BUS_W - FLAG_W;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb bus_o = sel_i ? {{PAD_W{1'b0}}, flags_i} : '0;
    end else begin : g_nopad
      always_comb bus_o = sel_i ? flags_i[BUS_W-1:0] : '0;
    end
  endgenerate
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
  import status_flag_pkg::*;
#(
  parameter int unsigned A_W = ALU_FLAG_W,
  parameter int unsigned S_W = STATE_FLAG_W,
  parameter int unsigned B_W = BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alu_ld_i,
  input  logic             alu_src_i,
  input  logic [A_W-1:0]   alu_flags_i,
  input  logic [S_W-1:0]   st_ld_i,
  input  logic [B_W-1:0]   z_bus_i,
  input  logic             left_sel_i,
  output logic [A_W+S_W-1:0] seq_flags_o,
  output logic [B_W-1:0]   left_o
);
  localparam int unsigned F_W = A_W + S_W;

  logic [A_W-1:0] alu_q;
  logic [S_W-1:0] st_q;

  alu_flag_grp #(.W(A_W)) u_alu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (alu_ld_i),
    .src_i  (alu_src_i),
    .alu_i  (alu_flags_i),
    .z_i    (z_bus_i[A_W-1:0]),
    .q_o    (alu_q)
  );

  // each state flag takes the Z bus bit at its own position
  for (genvar k = 0; k < S_W; k++) begin : g_st
    state_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (st_ld_i[k]),
      .d_i    (z_bus_i[A_W+k]),
      .q_o    (st_q[k])
    );
  end

  always_comb seq_flags_o = {st_q, alu_q};

  flag_bus_drv #(.FLAG_W(F_W), .BUS_W(B_W)) u_drv (
    .flags_i (seq_flags_o),
    .sel_i   (left_sel_i),
    .bus_o   (left_o)
  );
endmodule

// File: tb/status_flag_reg_tb.sv
module status_flag_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alu_ld, alu_src, left_sel;
  logic [3:0] alu_f;
  logic [1:0] st_ld;
  logic [7:0] z_bus;
  logic [5:0] seq_f;
  logic [7:0] left_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_reg dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .alu_ld_i    (alu_ld),
    .alu_src_i   (alu_src),
    .alu_flags_i (alu_f),
    .st_ld_i     (st_ld),
    .z_bus_i     (z_bus),
    .left_sel_i  (left_sel),
    .seq_flags_o (seq_f),
    .left_o      (left_b)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample just after the next rising edge
  task automatic step(input logic r, input logic ald, input logic src,
                      input logic [3:0] af, input logic [1:0] sl, input logic [7:0] z);
    @(negedge clk);
    rst_n = r; alu_ld = ald; alu_src = src; alu_f = af; st_ld = sl; z_bus = z;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    left_sel = 1'b1;
    step(1'b0, 1'b1, 1'b1, 4'hF, 2'b11, 8'hFF);
    chk("R7 reset over load", {2'b0, seq_f}, 8'h00);
    chk("R9 left after reset", left_b, 8'h00);
    left_sel = 1'b0;
  endtask

  task automatic t_alu_src;
    step(1'b1, 1'b1, 1'b1, 4'hA, 2'b00, 8'h05);
    chk("R1 R2 alu source", {2'b0, seq_f}, 8'h0A);
    step(1'b1, 1'b1, 1'b0, 4'hF, 2'b00, 8'h35);
    chk("R2 z source", {4'b0, seq_f[3:0]}, 8'h05);
    chk("R5 state unselected", {6'b0, seq_f[5:4]}, 8'h00);
  endtask

  task automatic t_alu_hold;
    step(1'b1, 1'b0, 1'b1, 4'hF, 2'b00, 8'hFF);
    chk("R3 hold alu src", {2'b0, seq_f}, 8'h05);
    step(1'b1, 1'b0, 1'b0, 4'h0, 2'b00, 8'h00);
    chk("R3 hold z src", {2'b0, seq_f}, 8'h05);
  endtask

  task automatic t_state;
    step(1'b1, 1'b0, 1'b0, 4'h0, 2'b01, 8'h10);
    chk("R4 set IE", {2'b0, seq_f}, 8'h15);
    step(1'b1, 1'b0, 1'b0, 4'h0, 2'b10, 8'hEF);
    chk("R4 set SUP", {2'b0, seq_f}, 8'h35);
    step(1'b1, 1'b0, 1'b0, 4'h0, 2'b01, 8'hEF);
    chk("R4 clear IE", {2'b0, seq_f}, 8'h25);
    chk("R5 SUP held", {7'b0, seq_f[5]}, 8'h01);
  endtask

  task automatic t_multi;
    step(1'b1, 1'b1, 1'b1, 4'h3, 2'b11, 8'h10);
    chk("R6 all selects", {2'b0, seq_f}, 8'h13);
  endtask

  task automatic t_left;
    @(negedge clk);
    left_sel = 1'b1; alu_ld = 1'b0; st_ld = 2'b00;
    #1;
    chk("R9 left selected", left_b, 8'h13);
    chk("R8 seq while selected", {2'b0, seq_f}, 8'h13);
    left_sel = 1'b0;
    #1;
    chk("R9 left deselected", left_b, 8'h00);
    chk("R8 seq while deselected", {2'b0, seq_f}, 8'h13);
  endtask

  task automatic t_reset_mid;
    step(1'b1, 1'b1, 1'b0, 4'h0, 2'b11, 8'h3F);
    chk("R6 restore all from z", {2'b0, seq_f}, 8'h3F);
    step(1'b0, 1'b1, 1'b0, 4'h0, 2'b11, 8'h3F);
    chk("R7 mid-run reset", {2'b0, seq_f}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; alu_ld = 1'b0; alu_src = 1'b0; alu_f = '0;
    st_ld = '0; z_bus = '0; left_sel = 1'b0;
    t_reset();
    t_alu_src();
    t_alu_hold();
    t_state();
    t_multi();
    t_left();
    t_reset_mid();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule